// File: doc/BRIEF.md
# BCD Real-Time Calendar Counter

This block keeps wall-clock time and calendar date in packed BCD. A one-cycle `tick` enable, expected at 100 Hz, advances a hundredths counter. Carries then ripple through seconds, minutes, hours, date, month and year, and the day-of-week field steps along with the date. Month lengths come from the month and year fields. February has 29 days in any year that is divisible by four.

The state is eight byte registers, presented together on one 64-bit bus. Register k sits in bits [8k+7:8k]. A host reads the whole set as a snapshot. It writes the set by pulsing `load` with a full 64-bit image. Two control bits share the day register. One stops the counter. The other decides whether an external active-low reset request reaches `abort_o`, which downstream access logic uses to drop a transfer in progress.

Top module: `bcd_calendar`

## Requirements
- R1: A synchronous active-high `rst` sets the register set to 64'h0001_0101_0000_0000. That is year 00, month 01, date 01, day register 01 (weekday 1, running, reset requests honoured), hours 00 in 24-hour form, and zero minutes, seconds and hundredths. The new value shows on `regs_o` after the clock edge.
- R2: When `tick` is high and the clock is running, register 0 (hundredths, 00..99) advances by one BCD step. The change shows on `regs_o` after the edge. Going from 99 to 00 advances register 1 (seconds, 00..59). Seconds going from 59 to 00 advances register 2 (minutes, 00..59). Minutes going from 59 to 00 advances the hours.
- R3: Register 3 bit 7 at 0 selects 24-hour form. The hour runs 00..23, with bits [5:4] as the BCD tens digit, so bit 5 is set for 20..23. Going from 23 to 00 advances the date.
- R4: Register 3 bit 7 at 1 selects 12-hour form. Bits [4:0] hold the hour 01..12 in BCD, and bit 5 at 1 means PM. The order is 11 AM→12 PM→01 PM and 11 PM→12 AM. The date advances only on the 11 PM→12 AM step.
- R5: Register 5 (date, BCD) ends at 30 for months 04, 06, 09 and 11, and at 31 for the other months. In February it ends at 29 when the year in register 7 is divisible by four, and at 28 otherwise.
- R6: After the last day of a month, the date returns to 01 and register 6 (month, 01..12) advances. Month 12 wraps to 01 and advances register 7 (year, 00..99). Year 99 wraps to 00.
- R7: Register 4 bits [2:0] hold the weekday, 1..7. It advances each time the date advances, and 7 wraps to 1.
- R8: While register 4 bit 5 is 1, `tick` has no effect and the whole register set holds its value.
- R9: `abort_o` is 1 exactly when `ext_rst_n` is low and register 4 bit 4 is 0. While bit 4 is 1, `abort_o` stays 0.
- R10: A `load` pulse replaces all eight registers with `load_data` at one clock edge, and the result shows on `regs_o` after that edge. A load takes priority over a `tick` in the same cycle. Later ticks count on from the loaded hundredths.
- R11: Bits with no meaning always read back as 0, whatever was loaded. These are bit 7 of registers 1 and 2, bit 6 of register 3, bits 7, 6 and 3 of register 4, bits 7 and 6 of register 5, and bits 7..5 of register 6.
- R12: In a cycle with neither `tick` nor `load`, the register set does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle count enable, nominally 100 Hz |
| load | input | 1 | Loads the full register set from `load_data` |
| load_data | input | 64 | Register image, register k in bits [8k+7:8k] |
| ext_rst_n | input | 1 | External active-low reset request |
| regs_o | output | 64 | Current register set, same layout as `load_data` |
| abort_o | output | 1 | Transfer-abort request gated by register 4 bit 4 |

## Verification
The in-design assertions assume that every loaded image is a legal calendar point. That means BCD digits, an hour inside the range of the selected form, a weekday of 1..7, and a date that exists in the loaded month. The date-range property depends on this, because the counter never repairs a bad image. Every image the stimulus loads is a real date and time. The images exist only to place the counter one tick before a rollover or a mode change, and unused bits are set only in images whose fields are still legal.

// File: rtl/cal_pkg.sv
package cal_pkg;
    localparam int REG_W    = 8;
    localparam int NUM_REGS = 8;
    localparam int SET_W    = REG_W * NUM_REGS;

    typedef logic [REG_W-1:0] creg_t;

    // Register k occupies bits [8k+7:8k]; the first field is the most significant.
    typedef struct packed {
        creg_t year;    // reg 7
        creg_t month;   // reg 6
        creg_t date;    // reg 5
        creg_t day;     // reg 4
        creg_t hour;    // reg 3
        creg_t minute;  // reg 2
        creg_t second;  // reg 1
        creg_t hund;    // reg 0
    } cal_regs_t;

    localparam logic [SET_W-1:0] FIELD_MASK = 64'hFF1F_3F37_BF7F_7FFF;
    localparam logic [SET_W-1:0] RESET_SET  = 64'h0001_0101_0000_0000;

    localparam int DAY_OSC_OFF = 5;
    localparam int DAY_RST_IGN = 4;
    localparam int HR_MODE12   = 7;
    localparam int HR_PM       = 5;

    localparam logic [2:0] DOW_FIRST = 3'd1;
    localparam logic [2:0] DOW_LAST  = 3'd7;

    function automatic creg_t bcd_inc(creg_t v);
        if (v[3:0] >= 4'd9)
            return {v[7:4] + 4'd1, 4'd0};
        else
            return {v[7:4], v[3:0] + 4'd1};
    endfunction

    function automatic logic [6:0] bcd_to_bin(creg_t v);
        return 7'(v[7:4]) * 7'd10 + 7'(v[3:0]);
    endfunction

    function automatic logic leap_year(creg_t y);
        return (bcd_to_bin(y) % 7'd4) == 7'd0;
    endfunction

    function automatic creg_t month_days(creg_t m, creg_t y);
        case (m)
            8'h02:                      return leap_year(y) ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
            default:                    return 8'h31;
        endcase
    endfunction
endpackage

// File: rtl/cal_wrap_counter.sv
module cal_wrap_counter
    import cal_pkg::*;
#(
    parameter creg_t LO = 8'h00,
    parameter creg_t HI = 8'h99
) (
    input  creg_t cur,
    input  logic  step,
    output creg_t nxt,
    output logic  carry
);
    assign carry = step && (cur == HI);
    assign nxt   = !step ? cur : (carry ? LO : bcd_inc(cur));
endmodule

// File: rtl/cal_hour_unit.sv
module cal_hour_unit
    import cal_pkg::*;
(
    input  creg_t cur,
    input  logic  step,
    output creg_t nxt,
    output logic  carry
);
    logic [5:0] t;

    always_comb begin
        nxt   = cur;
        carry = 1'b0;
        t     = '0;
        if (step) begin
            if (cur[HR_MODE12]) begin
                case (cur[4:0])
                    5'h11: begin
                        nxt   = {cur[7:6], ~cur[HR_PM], 5'h12};
                        carry = cur[HR_PM];
                    end
                    5'h12: nxt = {cur[7:5], 5'h01};
                    default: begin
                        t   = 6'(bcd_inc({3'b000, cur[4:0]}));
                        nxt = {cur[7:5], t[4:0]};
                    end
                endcase
            end else if (cur[5:0] == 6'h23) begin
                nxt   = {cur[7:6], 6'h00};
                carry = 1'b1;
            end else begin
                t   = 6'(bcd_inc({2'b00, cur[5:0]}));
                nxt = {cur[7:6], t};
            end
        end
    end
endmodule

// File: rtl/cal_date_unit.sv
module cal_date_unit
    import cal_pkg::*;
(
    input  creg_t date,
    input  creg_t month,
    input  creg_t year,
    input  creg_t day,
    input  logic  step,
    output creg_t nxt_date,
    output creg_t nxt_month,
    output creg_t nxt_year,
    output creg_t nxt_day
);
    logic       last_day;
    logic       mon_step;
    logic       yr_step;
    logic [2:0] dow_next;

    assign last_day = (date == month_days(month, year));
    assign mon_step = step && last_day;
    assign nxt_date = !step ? date : (last_day ? 8'h01 : bcd_inc(date));

    assign dow_next = (day[2:0] == DOW_LAST) ? DOW_FIRST : day[2:0] + 3'd1;
    assign nxt_day  = step ? {day[7:3], dow_next} : day;

    cal_wrap_counter #(.LO(8'h01), .HI(8'h12)) u_month (
        .cur   (month),
        .step  (mon_step),
        .nxt   (nxt_month),
        .carry (yr_step)
    );

    assign nxt_year = !yr_step ? year : ((year == 8'h99) ? 8'h00 : bcd_inc(year));
endmodule

// File: rtl/bcd_calendar.sv
module bcd_calendar
    import cal_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             load,
    input  logic [SET_W-1:0] load_data,
    input  logic             ext_rst_n,
    output logic [SET_W-1:0] regs_o,
    output logic             abort_o
);
    localparam int CHAIN = 3;
    localparam creg_t CHAIN_HI [CHAIN] = '{8'h99, 8'h59, 8'h59};

    cal_regs_t st, nx;
    logic      run;
    creg_t     ch_cur [CHAIN];
    creg_t     ch_nxt [CHAIN];
    logic      ch_step [CHAIN+1];
    creg_t     hour_nxt;
    logic      day_step;
    creg_t     date_nxt, month_nxt, year_nxt, day_nxt;

    assign run        = tick && !st.day[DAY_OSC_OFF];
    assign ch_cur[0]  = st.hund;
    assign ch_cur[1]  = st.second;
    assign ch_cur[2]  = st.minute;
    assign ch_step[0] = run;

    for (genvar gi = 0; gi < CHAIN; gi++) begin : g_chain
        cal_wrap_counter #(.LO(8'h00), .HI(CHAIN_HI[gi])) u_cnt (
            .cur   (ch_cur[gi]),
            .step  (ch_step[gi]),
            .nxt   (ch_nxt[gi]),
            .carry (ch_step[gi+1])
        );
    end

    cal_hour_unit u_hour (
        .cur   (st.hour),
        .step  (ch_step[CHAIN]),
        .nxt   (hour_nxt),
        .carry (day_step)
    );

    cal_date_unit u_date (
        .date      (st.date),
        .month     (st.month),
        .year      (st.year),
        .day       (st.day),
        .step      (day_step),
        .nxt_date  (date_nxt),
        .nxt_month (month_nxt),
        .nxt_year  (year_nxt),
        .nxt_day   (day_nxt)
    );

    always_comb begin
        nx        = st;
        nx.hund   = ch_nxt[0];
        nx.second = ch_nxt[1];
        nx.minute = ch_nxt[2];
        nx.hour   = hour_nxt;
        nx.day    = day_nxt;
        nx.date   = date_nxt;
        nx.month  = month_nxt;
        nx.year   = year_nxt;
    end

    always_ff @(posedge clk) begin
        if (rst)
            st <= cal_regs_t'(RESET_SET);
        else if (load)
            st <= cal_regs_t'(load_data & FIELD_MASK);
        else
            st <= nx;
    end

    assign regs_o  = st;
    assign abort_o = !ext_rst_n && !st.day[DAY_RST_IGN];

    // R12
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!tick && !load) |=> $stable(st));

    // R8
    frozen_chk: assert property (@(posedge clk) disable iff (rst)
        (st.day[DAY_OSC_OFF] && !load) |=> $stable(st));

    // R10
    load_apply_chk: assert property (@(posedge clk) disable iff (rst)
        load |=> (SET_W'(st) == ($past(load_data) & FIELD_MASK)));

    // R2
    sec_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!load && st.hund != 8'h99) |=> $stable(st.second));

    // R5
    date_range_chk: assert property (@(posedge clk) disable iff (rst)
        !load |=> (st.date != 8'h00 && st.date <= 8'h31));
endmodule

// File: tb/tb_bcd_calendar.sv
module tb_bcd_calendar;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick = 1'b0;
    logic        load = 1'b0;
    logic [63:0] load_data = '0;
    logic        ext_rst_n = 1'b1;
    logic [63:0] regs_o;
    logic        abort_o;

    int    checks = 0;
    int    fails = 0;
    bit    checking = 1'b0;
    bit    done = 1'b0;
    string tag = "R1";

    int m_hund, m_sec, m_min, m_hr, m_pm, m_m12, m_osc, m_ign, m_dow, m_date, m_mon, m_year;

    bcd_calendar dut (
        .clk(clk), .rst(rst), .tick(tick), .load(load), .load_data(load_data),
        .ext_rst_n(ext_rst_n), .regs_o(regs_o), .abort_o(abort_o)
    );

    always #10 clk = ~clk;

    function automatic logic [7:0] tobcd(int v);
        return 8'((v / 10) * 16 + (v % 10));
    endfunction

    function automatic int frombcd(logic [7:0] b);
        return int'(b[7:4]) * 10 + int'(b[3:0]);
    endfunction

    function automatic int mdays(int mo, int yr);
        if (mo == 2) return (yr % 4 == 0) ? 29 : 28;
        if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
        return 31;
    endfunction

    function automatic logic [63:0] model_pack();
        logic [7:0] hb;
        hb = m_m12 ? (8'h80 | 8'(m_pm << 5) | tobcd(m_hr)) : tobcd(m_hr);
        return {tobcd(m_year), tobcd(m_mon), tobcd(m_date),
                8'((m_osc << 5) | (m_ign << 4) | m_dow),
                hb, tobcd(m_min), tobcd(m_sec), tobcd(m_hund)};
    endfunction

    task automatic model_reset();
        m_hund = 0; m_sec = 0; m_min = 0; m_hr = 0; m_pm = 0; m_m12 = 0;
        m_osc = 0; m_ign = 0; m_dow = 1; m_date = 1; m_mon = 1; m_year = 0;
    endtask

    task automatic model_load(logic [63:0] d);
        m_hund = frombcd(d[7:0]);
        m_sec  = frombcd(d[15:8] & 8'h7F);
        m_min  = frombcd(d[23:16] & 8'h7F);
        m_m12  = int'(d[31]);
        m_pm   = m_m12 ? int'(d[29]) : 0;
        m_hr   = m_m12 ? frombcd(d[31:24] & 8'h1F) : frombcd(d[31:24] & 8'h3F);
        m_osc  = int'(d[37]);
        m_ign  = int'(d[36]);
        m_dow  = int'(d[34:32]);
        m_date = frombcd(d[47:40] & 8'h3F);
        m_mon  = frombcd(d[55:48] & 8'h1F);
        m_year = frombcd(d[63:56]);
    endtask

    task automatic model_next_day();
        m_dow = (m_dow == 7) ? 1 : m_dow + 1;
        m_date++;
        if (m_date > mdays(m_mon, m_year)) begin
            m_date = 1;
            m_mon++;
            if (m_mon > 12) begin
                m_mon = 1;
                m_year = (m_year + 1) % 100;
            end
        end
    endtask

    task automatic model_tick();
        bit day;
        day = 1'b0;
        m_hund++;
        if (m_hund < 100) return;
        m_hund = 0; m_sec++;
        if (m_sec < 60) return;
        m_sec = 0; m_min++;
        if (m_min < 60) return;
        m_min = 0;
        if (m_m12 != 0) begin
            if (m_hr == 11) begin
                day = (m_pm == 1);
                m_pm = 1 - m_pm;
                m_hr = 12;
            end else if (m_hr == 12) m_hr = 1;
            else m_hr++;
        end else begin
            m_hr++;
            if (m_hr == 24) begin m_hr = 0; day = 1'b1; end
        end
        if (day) model_next_day();
    endtask

    always @(posedge clk) begin
        logic [63:0] exp;
        logic        exp_ab;
        if (rst) model_reset();
        else if (load) model_load(load_data);
        else if (tick && m_osc == 0) model_tick();
        #5;
        if (checking && !done) begin
            exp    = model_pack();
            exp_ab = !ext_rst_n && (m_ign == 0);
            checks++;
            if (regs_o !== exp || abort_o !== exp_ab) begin
                fails++;
                $display("FAIL %s regs=%h abort=%b expected regs=%h abort=%b",
                         tag, regs_o, abort_o, exp, exp_ab);
            end
        end
    end

    task automatic expect_byte(int idx, logic [7:0] val, string req);
        checks++;
        if (regs_o[idx*8 +: 8] !== val) begin
            fails++;
            $display("FAIL %s reg%0d=%h expected %h", req, idx, regs_o[idx*8 +: 8], val);
        end
    endtask

    task automatic load_set(logic [7:0] yr, logic [7:0] mo, logic [7:0] dt, logic [7:0] dy,
                            logic [7:0] hr, logic [7:0] mi, logic [7:0] se, logic [7:0] hu,
                            bit with_tick);
        @(negedge clk);
        load = 1'b1; tick = with_tick; load_data = {yr, mo, dt, dy, hr, mi, se, hu};
        @(negedge clk);
        load = 1'b0; tick = 1'b0;
    endtask

    task automatic run_ticks(int n, int gap);
        for (int i = 0; i < n; i++) begin
            tick = 1'b1;
            @(negedge clk);
            tick = 1'b0;
            for (int g = 0; g < gap; g++) @(negedge clk);
        end
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            fails++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        checking = 1'b1;
        @(negedge clk);
        // R1: reset image
        tag = "R1";
        checks++;
        if (regs_o !== 64'h0001_0101_0000_0000) begin
            fails++;
            $display("FAIL R1 regs=%h expected %h", regs_o, 64'h0001_0101_0000_0000);
        end

        tag = "R12";
        repeat (5) @(negedge clk);

        tag = "R2";
        run_ticks(250, 0);
        run_ticks(40, 2);
        load_set(8'h25, 8'h03, 8'h10, 8'h02, 8'h14, 8'h59, 8'h59, 8'h98, 1'b0);
        run_ticks(3, 0);
        expect_byte(2, 8'h00, "R2");
        expect_byte(3, 8'h15, "R2");

        // R10: load wins over a tick in the same cycle, then counting resumes
        tag = "R10";
        load_set(8'h30, 8'h07, 8'h04, 8'h05, 8'h08, 8'h30, 8'h12, 8'h42, 1'b1);
        expect_byte(0, 8'h42, "R10");
        run_ticks(1, 0);
        expect_byte(0, 8'h43, "R10");

        // R3: 24-hour rollover into the next date
        tag = "R3";
        load_set(8'h23, 8'h02, 8'h28, 8'h03, 8'h23, 8'h59, 8'h59, 8'h99, 1'b0);
        run_ticks(1, 0);
        expect_byte(3, 8'h00, "R3");
        expect_byte(5, 8'h01, "R3");
        load_set(8'h23, 8'h02, 8'h10, 8'h03, 8'h19, 8'h59, 8'h59, 8'h99, 1'b0);
        run_ticks(1, 0);
        expect_byte(3, 8'h20, "R3");

        // R5: month lengths
        tag = "R5";
        load_set(8'h24, 8'h02, 8'h28, 8'h03, 8'h23, 8'h59, 8'h59, 8'h99, 1'b0);
        run_ticks(1, 0);
        expect_byte(5, 8'h29, "R5");
        load_set(8'h24, 8'h02, 8'h29, 8'h03, 8'h23, 8'h59, 8'h59, 8'h99, 1'b0);
        run_ticks(1, 0);
        expect_byte(6, 8'h03, "R5");
        for (int k = 0; k < 4; k++) begin
            logic [7:0] mo;
            mo = (k == 0) ? 8'h04 : (k == 1) ? 8'h06 : (k == 2) ? 8'h09 : 8'h11;
            load_set(8'h21, mo, 8'h30, 8'h01, 8'h23, 8'h59, 8'h59, 8'h99, 1'b0);
            run_ticks(1, 0);
            expect_byte(5, 8'h01, "R5");
        end
        load_set(8'h21, 8'h01, 8'h30, 8'h01, 8'h23, 8'h59, 8'h59, 8'h99, 1'b0);
        run_ticks(1, 0);
        expect_byte(5, 8'h31, "R5");

        // R6 and R7: year wrap and weekday wrap
        tag = "R6";
        load_set(8'h99, 8'h12, 8'h31, 8'h07, 8'h23, 8'h59, 8'h59, 8'h99, 1'b0);
        run_ticks(1, 0);
        expect_byte(7, 8'h00, "R6");
        expect_byte(6, 8'h01, "R6");
        tag = "R7";
        expect_byte(4, 8'h01, "R7");
        run_ticks(20, 0);

        // R4: 12-hour sequence
        tag = "R4";
        load_set(8'h22, 8'h05, 8'h10, 8'h02, 8'h91, 8'h59, 8'h59, 8'h99, 1'b0);
        run_ticks(1, 0);
        expect_byte(3, 8'hB2, "R4");
        load_set(8'h22, 8'h05, 8'h10, 8'h02, 8'hB2, 8'h59, 8'h59, 8'h99, 1'b0);
        run_ticks(1, 0);
        expect_byte(3, 8'hA1, "R4");
        load_set(8'h22, 8'h05, 8'h10, 8'h02, 8'hB1, 8'h59, 8'h59, 8'h99, 1'b0);
        run_ticks(1, 0);
        expect_byte(3, 8'h92, "R4");
        expect_byte(5, 8'h11, "R4");
        load_set(8'h22, 8'h05, 8'h10, 8'h02, 8'h92, 8'h59, 8'h59, 8'h99, 1'b0);
        run_ticks(1, 0);
        expect_byte(3, 8'h81, "R4");
        load_set(8'h22, 8'h05, 8'h10, 8'h02, 8'h89, 8'h59, 8'h59, 8'h99, 1'b0);
        run_ticks(1, 0);
        expect_byte(3, 8'h90, "R4");

        // R11: unused bits read as zero (clock stopped in this image)
        tag = "R11";
        load_set(8'h26, 8'hE7, 8'hD5, 8'hEB, 8'h49, 8'h95, 8'hB0, 8'h50, 1'b0);
        expect_byte(1, 8'h30, "R11");
        expect_byte(2, 8'h15, "R11");
        expect_byte(3, 8'h09, "R11");
        expect_byte(4, 8'h23, "R11");
        expect_byte(5, 8'h15, "R11");
        expect_byte(6, 8'h07, "R11");

        // R8: stopped clock ignores ticks
        tag = "R8";
        run_ticks(30, 0);
        expect_byte(0, 8'h50, "R8");
        load_set(8'h26, 8'h07, 8'h15, 8'h03, 8'h09, 8'h15, 8'h30, 8'h50, 1'b0);
        run_ticks(10, 0);
        expect_byte(0, 8'h60, "R8");

        // R9: reset-request gating
        tag = "R9";
        ext_rst_n = 1'b0;
        @(negedge clk);
        checks++;
        if (abort_o !== 1'b1) begin
            fails++;
            $display("FAIL R9 abort=%b expected 1", abort_o);
        end
        load_set(8'h26, 8'h07, 8'h15, 8'h13, 8'h09, 8'h15, 8'h30, 8'h50, 1'b0);
        checks++;
        if (abort_o !== 1'b0) begin
            fails++;
            $display("FAIL R9 abort=%b expected 0", abort_o);
        end
        run_ticks(5, 1);
        ext_rst_n = 1'b1;
        repeat (3) @(negedge clk);

        tag = "R12";
        repeat (5) @(negedge clk);
        expect_byte(0, 8'h55, "R12");

        done = 1'b1;
        summary();
        $finish;
    end
endmodule